// File: doc/BRIEF.md
# Flash Word Read Buffer

This block is a small flip-flop cache that sits in front of one flash bank and holds the most recently fetched flash words. A flash word is wider than a bus word, so one fetch covers several bus words. When software or a host walks through memory in order, the later bus words of a fetched flash word come straight from this buffer and the flash is not accessed again. A lookup is answered in the same cycle. A miss is left to the fetch path, which later hands the returned word and its 4-bit integrity code to the buffer through the fill port.

Each entry holds a flash-word address, the descrambled word and its short integrity code. Fills take victim entries in turn. Program and erase notifications remove entries that could go stale: a page operation removes only the entries in that page, and a bank operation removes all of them. The buffer starts switched off and begins to serve once an initialization request arrives. The start of RMA entry switches it off for good, and only a reset turns it back on. On every hit the stored integrity code is checked again against the stored word, so a corrupted entry is reported as an error.

Top module: `fwb_read_buffer`

## Requirements
- R1: After reset, and until `init_req_i` has been seen, every lookup misses and fills are dropped. A word filled in this period does not hit after initialization.
- R2: A fill while serving stores the word. A lookup of that flash-word address in any later cycle raises `hit_o` in the same cycle as `rd_req_i`. An address not held misses.
- R3: `rd_addr_i` is a bus-word address. Its low bit selects the bus word: 0 returns bits 31:0 of the flash word and 1 returns bits 63:32. The remaining bits form the flash-word address, so both bus words of a filled flash word hit.
- R4: A fill to an address already held overwrites that entry in place and does not move the victim pointer. Later lookups return the new word. No two valid entries ever hold the same address.
- R5: A fill of a new address goes to the entry under a round-robin pointer that starts at entry 0 and steps 0,1,2,3,0. The fifth distinct fill evicts the first word, and the sixth evicts the second.
- R6: A page invalidate (`inval_bank_i`=0) removes only the entries whose address shares the page of `inval_addr_i`. The page number is the flash-word address shifted right by 3, so there are 8 words per page.
- R7: A bank invalidate (`inval_bank_i`=1) removes every entry.
- R8: When an invalidate and a fill happen in the same cycle and the fill address lies inside the invalidated range, the fill is dropped and the pointer holds. When the fill address is outside that range, the fill proceeds.
- R9: A pulse on `rma_start_i` clears every entry, blocks hits from that cycle on, and drops fills. A later `init_req_i` does not re-enable the buffer before reset.
- R10: The integrity code is the XOR of the sixteen 4-bit nibbles of the 64-bit word. On a hit whose stored code differs from that fold of the stored word, `hit_err_o` is 1 and the stored data is still returned. A consistent entry gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_req_i | input | 1 | Initialization request, enables serving |
| rma_start_i | input | 1 | RMA entry start, disables the buffer until reset |
| rd_req_i | input | 1 | Lookup request |
| rd_addr_i | input | 17 | Lookup bus-word address |
| hit_o | output | 1 | Lookup hit, same cycle |
| hit_rdata_o | output | 32 | Selected bus word of the hit entry |
| hit_err_o | output | 1 | Integrity mismatch on the hit entry |
| fill_i | input | 1 | Store a returned flash word |
| fill_addr_i | input | 16 | Flash-word address of the fill |
| fill_data_i | input | 64 | Descrambled flash word |
| fill_icv_i | input | 4 | Integrity code of the fill word |
| inval_i | input | 1 | Program/erase notification |
| inval_bank_i | input | 1 | 1 = whole bank, 0 = one page |
| inval_addr_i | input | 16 | Flash-word address inside the affected page |

## Verification
The bench fills all four entries and adds more, so it catches a pointer that advances on an in-place rewrite or skips entries. Such a pointer would evict the wrong word, and an old word would go on hitting. It runs page invalidates beside neighbouring pages to expose an invalidate that compares whole addresses or ignores the page, which would leave stale words or wipe too much. It fires an invalidate and a fill in the same cycle, both inside and outside the page, to catch a fill that sneaks in stale data or one that is wrongly refused. It also stores a word with a bad integrity code, which a design that skips the check on hit would return without an error, and it sends a second initialization after RMA, which a buffer that is not locked would answer with hits.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  // Serving state of the buffer; LOCKED is left only by reset.
  typedef enum logic [1:0] {
    FWB_OFF    = 2'b00,
    FWB_ON     = 2'b01,
    FWB_LOCKED = 2'b10
  } fwb_mode_e;
endpackage

// File: rtl/fwb_mode_ctrl.sv
module fwb_mode_ctrl
  import fwb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_req_i,
  input  logic rma_start_i,
  output logic serve_o,
  output logic locked_o
);
  fwb_mode_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rma_start_i) begin
      state_d = FWB_LOCKED;
    end else begin
      case (state_q)
        FWB_OFF:    if (init_req_i) state_d = FWB_ON;
        FWB_ON:     state_d = FWB_ON;
        FWB_LOCKED: state_d = FWB_LOCKED;
        default:    state_d = FWB_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FWB_OFF;
    else         state_q <= state_d;
  end

  assign serve_o  = (state_q == FWB_ON);
  assign locked_o = (state_q == FWB_LOCKED);

  // R9: RMA start leaves the buffer locked and not serving
  assert_rma_locks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rma_start_i |=> (locked_o && !serve_o));
  // R9: the lock is never released without reset
  assert_lock_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
endmodule

// File: rtl/fwb_victim.sv
module fwb_victim #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) begin
      if (ptr_q == IDX_W'(ENTRIES - 1)) ptr_d = '0;
      else                              ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R5: the pointer moves only for fills of new addresses
  assert_ptr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
  assert_ptr_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_o != $past(ptr_o)));
endmodule

// File: rtl/fwb_entry.sv
module fwb_entry #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int ICV_W  = 4,
  localparam int NIB   = DATA_W / ICV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ICV_W-1:0]  wr_icv_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              icv_bad_o
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [ICV_W-1:0]  icv_q;
  logic [ICV_W-1:0]  fold;

  // a write wins over a clear; the parent never asks for both on a disable
  always_comb begin
    valid_d = valid_q;
    if (wr_i)       valid_d = 1'b1;
    else if (clr_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      icv_q  <= '0;
    end else if (wr_i) begin
      addr_q <= wr_addr_i;
      data_q <= wr_data_i;
      icv_q  <= wr_icv_i;
    end
  end

  // re-derive the integrity code from the stored word
  always_comb begin
    fold = '0;
    for (int k = 0; k < NIB; k++) fold = fold ^ data_q[k*ICV_W +: ICV_W];
  end

  assign valid_o   = valid_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign icv_bad_o = (fold != icv_q);

  // R2: a written entry is valid and holds the written address
  assert_fill_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (valid_o && addr_o == $past(wr_addr_i)));
endmodule

// File: rtl/fwb_read_buffer.sv
module fwb_read_buffer #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 64,
  parameter int BUS_W      = 32,
  parameter int ICV_W      = 4,
  parameter int PAGE_WORDS = 8,
  localparam int SEL_W     = $clog2(DATA_W / BUS_W),
  localparam int PG_LSB    = $clog2(PAGE_WORDS),
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    init_req_i,
  input  logic                    rma_start_i,
  input  logic                    rd_req_i,
  input  logic [ADDR_W+SEL_W-1:0] rd_addr_i,
  output logic                    hit_o,
  output logic [BUS_W-1:0]        hit_rdata_o,
  output logic                    hit_err_o,
  input  logic                    fill_i,
  input  logic [ADDR_W-1:0]       fill_addr_i,
  input  logic [DATA_W-1:0]       fill_data_i,
  input  logic [ICV_W-1:0]        fill_icv_i,
  input  logic                    inval_i,
  input  logic                    inval_bank_i,
  input  logic [ADDR_W-1:0]       inval_addr_i
);
  logic serve, locked;
  logic [IDX_W-1:0] ptr;

  logic [ADDR_W-1:0] rd_word;
  logic [SEL_W-1:0]  rd_sel;
  assign rd_word = rd_addr_i[ADDR_W+SEL_W-1:SEL_W];
  assign rd_sel  = rd_addr_i[SEL_W-1:0];

  logic [ENTRIES-1:0] ent_valid, ent_bad, match_rd, match_fill, inval_hit, ent_wr, ent_clr;
  logic [ADDR_W-1:0]  ent_addr [ENTRIES];
  logic [DATA_W-1:0]  ent_data [ENTRIES];

  logic             fill_blocked, do_fill, dup_any, hit_any, adv;
  logic [IDX_W-1:0] dup_idx, hit_idx, tgt;
  logic [DATA_W-1:0] hit_word;

  fwb_mode_ctrl u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_req_i  (init_req_i),
    .rma_start_i (rma_start_i),
    .serve_o     (serve),
    .locked_o    (locked)
  );

  fwb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .ptr_o  (ptr)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign match_rd[i]   = ent_valid[i] && (ent_addr[i] == rd_word);
    assign match_fill[i] = ent_valid[i] && (ent_addr[i] == fill_addr_i);
    assign inval_hit[i]  = inval_i && (inval_bank_i ||
                           (ent_addr[i][ADDR_W-1:PG_LSB] == inval_addr_i[ADDR_W-1:PG_LSB]));
    assign ent_wr[i]     = do_fill && (tgt == IDX_W'(i));
    assign ent_clr[i]    = !serve || rma_start_i || inval_hit[i];

    fwb_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ICV_W(ICV_W)) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (ent_wr[i]),
      .clr_i     (ent_clr[i]),
      .wr_addr_i (fill_addr_i),
      .wr_data_i (fill_data_i),
      .wr_icv_i  (fill_icv_i),
      .valid_o   (ent_valid[i]),
      .addr_o    (ent_addr[i]),
      .data_o    (ent_data[i]),
      .icv_bad_o (ent_bad[i])
    );
  end

  // lowest matching index; at most one entry matches
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    dup_any = 1'b0;
    dup_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_rd[i])   begin hit_any = 1'b1; hit_idx = IDX_W'(i); end
      if (match_fill[i]) begin dup_any = 1'b1; dup_idx = IDX_W'(i); end
    end
  end

  assign fill_blocked = inval_i && (inval_bank_i ||
                        (fill_addr_i[ADDR_W-1:PG_LSB] == inval_addr_i[ADDR_W-1:PG_LSB]));
  assign do_fill = fill_i && serve && !rma_start_i && !fill_blocked;
  assign tgt     = dup_any ? dup_idx : ptr;
  assign adv     = do_fill && !dup_any;

  assign hit_word    = ent_data[hit_idx];
  assign hit_o       = rd_req_i && serve && !rma_start_i && hit_any;
  assign hit_rdata_o = hit_word[rd_sel*BUS_W +: BUS_W];
  assign hit_err_o   = hit_o && ent_bad[hit_idx];

  // R4: duplicates never exist among valid entries
  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_rd));
  // R7: bank invalidate empties the buffer
  assert_bank_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_i && inval_bank_i) |=> (ent_valid == '0));
  // R9: a locked buffer never hits
  assert_locked_no_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !hit_o);
  // R8: a fill inside the invalidated range leaves no entry for that address
  assert_inval_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && fill_blocked) |=> (match_fill == '0 || $past(fill_addr_i) != fill_addr_i));
endmodule

// File: tb/fwb_read_buffer_bench.sv
`timescale 1ns/1ps
module fwb_read_buffer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        init_req_i, rma_start_i, rd_req_i;
  logic [16:0] rd_addr_i;
  logic        hit_o, hit_err_o;
  logic [31:0] hit_rdata_o;
  logic        fill_i;
  logic [15:0] fill_addr_i;
  logic [63:0] fill_data_i;
  logic [3:0]  fill_icv_i;
  logic        inval_i, inval_bank_i;
  logic [15:0] inval_addr_i;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic        hit;
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk_i = ~clk_i;

  fwb_read_buffer u_fwb_read_buffer (
    .clk_i, .rst_ni, .init_req_i, .rma_start_i, .rd_req_i, .rd_addr_i,
    .hit_o, .hit_rdata_o, .hit_err_o, .fill_i, .fill_addr_i, .fill_data_i,
    .fill_icv_i, .inval_i, .inval_bank_i, .inval_addr_i
  );

  function automatic logic [63:0] word_of(input logic [15:0] a, input logic [15:0] salt);
    return {a ^ 16'hC3C3, salt, a, ~salt};
  endfunction

  function automatic logic [3:0] icv_of(input logic [63:0] d);
    logic [3:0] f = '0;
    for (int k = 0; k < 16; k++) f = f ^ d[k*4 +: 4];
    return f;
  endfunction

  task automatic quiet();
    init_req_i = 0; rma_start_i = 0; rd_req_i = 0; rd_addr_i = '0;
    fill_i = 0; fill_addr_i = '0; fill_data_i = '0; fill_icv_i = '0;
    inval_i = 0; inval_bank_i = 0; inval_addr_i = '0;
  endtask

  task automatic step();
    @(posedge clk_i); #1; quiet();
  endtask

  task automatic fill(input logic [15:0] a, input logic [15:0] salt, input bit bad);
    step();
    fill_i = 1; fill_addr_i = a; fill_data_i = word_of(a, salt);
    fill_icv_i = icv_of(word_of(a, salt)) ^ {3'b000, bad};
  endtask

  task automatic inval(input logic [15:0] a, input bit bank);
    step();
    inval_i = 1; inval_bank_i = bank; inval_addr_i = a;
  endtask

  task automatic fill_inval(input logic [15:0] fa, input logic [15:0] salt, input logic [15:0] ia);
    fill(fa, salt, 1'b0);
    inval_i = 1; inval_bank_i = 0; inval_addr_i = ia;
  endtask

  task automatic pulse_init();  step(); init_req_i = 1;  endtask
  task automatic pulse_rma();   step(); rma_start_i = 1; endtask

  // driver: push the expectation, then present the lookup
  task automatic look(input logic [15:0] a, input bit sel, input bit eh,
                      input logic [15:0] salt, input bit ee, input string tag);
    exp_t e;
    logic [63:0] w = word_of(a, salt);
    e.hit = eh; e.data = sel ? w[63:32] : w[31:0]; e.err = ee; e.tag = tag;
    sb.push_back(e);
    step();
    rd_req_i = 1; rd_addr_i = {a, sel};
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && rd_req_i) begin
      exp_t e;
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL scoreboard empty (R2) actual=lookup expected=none");
      end else begin
        e = sb.pop_front();
        n_chk++;
        if (hit_o !== e.hit ||
            (e.hit && (hit_rdata_o !== e.data || hit_err_o !== e.err))) begin
          n_bad++;
          $display("FAIL %s addr=%h hit=%0b/%0b data=%h/%h err=%0b/%0b (actual/expected)",
                   e.tag, rd_addr_i, hit_o, e.hit, hit_rdata_o, e.data, hit_err_o, e.err);
        end
      end
    end
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (R1..all) actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    quiet();
    rst_ni = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1: reset state and pre-init behaviour
    look(16'h05, 0, 0, 0, 0, "R1");
    fill(16'h05, 1, 0);
    pulse_init();
    look(16'h05, 0, 0, 0, 0, "R1");

    // R2 / R3: basic fill and both bus words
    fill(16'h10, 2, 0);
    look(16'h10, 0, 1, 2, 0, "R2");
    look(16'h10, 1, 1, 2, 0, "R3");
    look(16'h11, 0, 0, 0, 0, "R2");

    // R5: round robin
    fill(16'h11, 3, 0); fill(16'h12, 4, 0); fill(16'h13, 5, 0);
    fill(16'h20, 6, 0);
    look(16'h10, 0, 0, 0, 0, "R5");
    look(16'h11, 0, 1, 3, 0, "R5");
    fill(16'h21, 7, 0);
    look(16'h11, 0, 0, 0, 0, "R5");
    look(16'h12, 1, 1, 4, 0, "R5");

    // R4: rewrite in place, pointer stays on entry 2
    fill(16'h12, 8, 0);
    look(16'h12, 0, 1, 8, 0, "R4");
    fill(16'h22, 9, 0);
    look(16'h12, 0, 0, 0, 0, "R4");
    look(16'h13, 0, 1, 5, 0, "R4");
    look(16'h22, 1, 1, 9, 0, "R4");

    // R6: page invalidate, page = addr >> 3
    inval(16'h13, 0);
    look(16'h13, 0, 0, 0, 0, "R6");
    look(16'h20, 0, 1, 6, 0, "R6");
    look(16'h21, 1, 1, 7, 0, "R6");

    // R8: same-cycle invalidate and fill
    fill_inval(16'h14, 10, 16'h10);
    look(16'h14, 0, 0, 0, 0, "R8");
    fill_inval(16'h30, 11, 16'h17);
    look(16'h30, 0, 1, 11, 0, "R8");
    look(16'h22, 0, 1, 9, 0, "R8");

    // R10: bad integrity code, goes to entry 0
    fill(16'h40, 12, 1);
    look(16'h40, 0, 1, 12, 1, "R10");
    look(16'h40, 1, 1, 12, 1, "R10");
    look(16'h20, 0, 0, 0, 0, "R5");
    look(16'h30, 1, 1, 11, 0, "R10");

    // R7: bank invalidate
    inval(16'h00, 1);
    look(16'h21, 0, 0, 0, 0, "R7");
    look(16'h30, 0, 0, 0, 0, "R7");

    // R9: RMA lock
    fill(16'h50, 13, 0);
    look(16'h50, 0, 1, 13, 0, "R9");
    pulse_rma();
    look(16'h50, 0, 0, 0, 0, "R9");
    fill(16'h51, 14, 0);
    pulse_init();
    look(16'h51, 0, 0, 0, 0, "R9");
    look(16'h50, 1, 0, 0, 0, "R9");

    step();
    @(negedge clk_i);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard leftover (R2) actual=%0d expected=0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule